// File: doc/BRIEF.md
# Microcode Sequencer with Opcode Dispatch

This block is the control unit of a microcoded processor. It holds a control store of microwords and walks through it one word per cycle. Each word drives a vector of datapath control bits: multiplexer selects, register load strobes, memory read and write strobes, and an ALU function field. Each word also carries a next-address operation. The sequencer supports five kinds of flow. The default is to fall through to the next word. A word can jump unconditionally. It can branch when a test is true or when a test is false. It can also dispatch multiway into a per-instruction routine, selected by the primary and extended opcode fields of the instruction register.

The test used by a conditional branch is not chosen by the microword. It comes from the instruction's first register field. That field is compared against zero and negative flags, which the datapath has already latched. Every instruction routine ends by jumping back to a shared two-word fetch routine at address 0. Opcodes that have no routine land in a trap routine, which also returns to fetch.

The control store is a ROM that is initialised inside the design. It is read through an output register, so the control bits and the micro-address both leave the block registered and change on the same clock edge.

Top module: `useq_sequencer`

## Requirements
- R1: Reset `rst` is synchronous and active high. After a clock edge with `rst` high, `upc_o` is 0. `ctrl_o` then shows the first fetch word: bit 18 (MAR load) and bit 19 (PC load) are set, and bit 20 (IR load) is clear. Reset wins over any next-address operation, including a dispatch in that cycle.
- R2: Fetch word 0 always falls through to word 1. Word 1 asserts bit 16 (memory read) and bit 20 (IR load). Word 1 is the only word that asserts bit 20, and it performs the opcode dispatch.
- R3: The dispatch target depends on the opcode fields. For `ir_op`=0, `ir_xop` 0 goes to 2; `ir_xop` 1..10 goes to 4; `ir_xop` 11 goes to 14; `ir_xop` 12 goes to 22. Other `ir_op` values map as follows: 1 to 8, 2 to 11, 3 to 17, 4 to 19, 5 to 25, 6 to 27, 7 to 28, 8 to 10, and 9..19 to 6. Every other combination goes to 29 (trap).
- R4: A word without a branch operation is followed by the next address. Routines at entries 2, 4, 6, 8 and 17 last two words. Routines at 11, 14, 19 and 22 last three words. Routines at 10, 27, 28 and 29 last one word. The last word of every routine jumps to address 0.
- R5: The condition code is `ir_r1`, and each code is tested against `flag_zero` (Z) and `flag_neg` (N): 0 is always true, 1 is Z, 2 is not Z, 3 is N, 4 is N or Z, 5 is not N, and 6 is neither N nor Z.
- R6: Condition codes 7 to 31 are never true.
- R7: The conditional-jump routine at 25 goes to 0 when the condition is false. When the condition is true it goes to 26, and 26 then returns to 0.
- R8: Bit 17 (memory write) is asserted only in the last word of the three store routines, at addresses 18, 21 and 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_op | input | OP_W (5) | Primary opcode field of the instruction register |
| ir_xop | input | XOP_W (12) | Extended opcode field of the instruction register |
| ir_r1 | input | SEL_W (5) | First register field, used as the condition code |
| flag_zero | input | 1 | Latched zero flag from the datapath |
| flag_neg | input | 1 | Latched negative flag from the datapath |
| ctrl_o | output | 25 | Registered datapath control bits of the current microword |
| upc_o | output | AW (6) | Current micro-address |

## Verification
Two of the block's functions can act in the same cycle: the synchronous reset and the opcode dispatch in fetch word 1. The bench provokes this by loading a valid opcode while the sequencer is at word 0. It then raises reset exactly while word 1 is current. It judges the result one edge later: the micro-address must be 0 rather than the routine entry, and the IR-load bit must be clear. A scoreboard covers the normal flow. For every instruction it queues the full expected address trail, including the condition-dependent length of the jump routine, and the expected memory-write and IR-load bits.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int CTRL_W = 25;
  localparam int TGT_W  = 8;

  // control bit positions
  localparam int CB_MAR_PC   = 0;
  localparam int CB_MAR_ADS  = 1;
  localparam int CB_MAR_T    = 2;
  localparam int CB_PC_INC   = 3;
  localparam int CB_PC_ADS   = 4;
  localparam int CB_PC_REG   = 5;
  localparam int CB_WB_MEM   = 6;
  localparam int CB_WB_T     = 7;
  localparam int CB_WB_PC    = 8;
  localparam int CB_WB_ADS   = 9;
  localparam int CB_A_R1     = 10;
  localparam int CB_A_R2     = 11;
  localparam int CB_RY_R3    = 12;
  localparam int CB_B_RY     = 13;
  localparam int CB_B_IM     = 14;
  localparam int CB_DST_R1   = 15;
  localparam int CB_MEM_RD   = 16;
  localparam int CB_MEM_WR   = 17;
  localparam int CB_LD_MAR   = 18;
  localparam int CB_LD_PC    = 19;
  localparam int CB_LD_IR    = 20;
  localparam int CB_LD_REG   = 21;
  localparam int CB_LD_T     = 22;
  localparam int CB_ALU_LSB  = 23;

  localparam int ALU_IDLE  = 0;
  localparam int ALU_ADD   = 1;
  localparam int ALU_PASSA = 2;
  localparam int ALU_INSN  = 3;

  // routine entry points
  localparam int UA_FETCH  = 0;
  localparam int UA_FETCH2 = 1;
  localparam int UA_ADD    = 2;
  localparam int UA_BOP    = 4;
  localparam int UA_OPIM   = 6;
  localparam int UA_LDA    = 8;
  localparam int UA_LDI    = 10;
  localparam int UA_LDD    = 11;
  localparam int UA_LDX    = 14;
  localparam int UA_STA    = 17;
  localparam int UA_STD    = 19;
  localparam int UA_STX    = 22;
  localparam int UA_JCC    = 25;
  localparam int UA_JAL    = 27;
  localparam int UA_JR     = 28;
  localparam int UA_TRAP   = 29;

  typedef enum logic [2:0] {
    SQ_NEXT   = 3'd0,
    SQ_JMP    = 3'd1,
    SQ_JF     = 3'd2,
    SQ_JT     = 3'd3,
    SQ_DECODE = 3'd4
  } seq_op_e;

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    seq_op_e           op;
    logic [TGT_W-1:0]  tgt;
  } uword_t;

  function automatic logic [CTRL_W-1:0] cb(input int idx);
    logic [CTRL_W-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  function automatic logic [CTRL_W-1:0] alu(input int code);
    logic [CTRL_W-1:0] v;
    v = '0;
    v[CB_ALU_LSB +: 2] = 2'(code);
    return v;
  endfunction

  function automatic uword_t mk(input logic [CTRL_W-1:0] c, input seq_op_e o, input int t);
    uword_t w;
    w.ctrl = c;
    w.op   = o;
    w.tgt  = TGT_W'(t);
    return w;
  endfunction

  // microprogram contents, one word per address
  function automatic uword_t uword_at(input int a);
    logic [CTRL_W-1:0] rr, ri, wbt, ldm;
    rr  = cb(CB_A_R2) | cb(CB_RY_R3) | cb(CB_B_RY);
    ri  = cb(CB_A_R2) | cb(CB_B_IM);
    wbt = cb(CB_WB_T) | cb(CB_DST_R1) | cb(CB_LD_REG);
    ldm = cb(CB_MEM_RD) | cb(CB_WB_MEM) | cb(CB_DST_R1) | cb(CB_LD_REG);
    case (a)
      0:  return mk(cb(CB_MAR_PC) | cb(CB_LD_MAR) | cb(CB_PC_INC) | cb(CB_LD_PC), SQ_NEXT, 0);
      1:  return mk(cb(CB_MEM_RD) | cb(CB_LD_IR), SQ_DECODE, 0);
      2:  return mk(rr | alu(ALU_ADD) | cb(CB_LD_T), SQ_NEXT, 0);
      3:  return mk(wbt, SQ_JMP, UA_FETCH);
      4:  return mk(rr | alu(ALU_INSN) | cb(CB_LD_T), SQ_NEXT, 0);
      5:  return mk(wbt, SQ_JMP, UA_FETCH);
      6:  return mk(ri | alu(ALU_INSN) | cb(CB_LD_T), SQ_NEXT, 0);
      7:  return mk(wbt, SQ_JMP, UA_FETCH);
      8:  return mk(cb(CB_MAR_ADS) | cb(CB_LD_MAR), SQ_NEXT, 0);
      9:  return mk(ldm, SQ_JMP, UA_FETCH);
      10: return mk(cb(CB_DST_R1) | cb(CB_WB_ADS) | cb(CB_LD_REG), SQ_JMP, UA_FETCH);
      11: return mk(ri | alu(ALU_ADD) | cb(CB_LD_T), SQ_NEXT, 0);
      12: return mk(cb(CB_MAR_T) | cb(CB_LD_MAR), SQ_NEXT, 0);
      13: return mk(ldm, SQ_JMP, UA_FETCH);
      14: return mk(rr | alu(ALU_ADD) | cb(CB_LD_T), SQ_NEXT, 0);
      15: return mk(cb(CB_MAR_T) | cb(CB_LD_MAR), SQ_NEXT, 0);
      16: return mk(ldm, SQ_JMP, UA_FETCH);
      17: return mk(cb(CB_MAR_ADS) | cb(CB_LD_MAR) | cb(CB_A_R1) | alu(ALU_PASSA) | cb(CB_LD_T),
                    SQ_NEXT, 0);
      18: return mk(cb(CB_MEM_WR), SQ_JMP, UA_FETCH);
      19: return mk(ri | alu(ALU_ADD) | cb(CB_LD_T), SQ_NEXT, 0);
      20: return mk(cb(CB_MAR_T) | cb(CB_LD_MAR) | cb(CB_A_R1) | alu(ALU_PASSA) | cb(CB_LD_T),
                    SQ_NEXT, 0);
      21: return mk(cb(CB_MEM_WR), SQ_JMP, UA_FETCH);
      22: return mk(rr | alu(ALU_ADD) | cb(CB_LD_T), SQ_NEXT, 0);
      23: return mk(cb(CB_MAR_T) | cb(CB_LD_MAR) | cb(CB_A_R1) | alu(ALU_PASSA) | cb(CB_LD_T),
                    SQ_NEXT, 0);
      24: return mk(cb(CB_MEM_WR), SQ_JMP, UA_FETCH);
      25: return mk('0, SQ_JF, UA_FETCH);
      26: return mk(cb(CB_PC_ADS) | cb(CB_LD_PC), SQ_JMP, UA_FETCH);
      27: return mk(cb(CB_WB_PC) | cb(CB_DST_R1) | cb(CB_LD_REG) | cb(CB_PC_ADS) | cb(CB_LD_PC),
                    SQ_JMP, UA_FETCH);
      28: return mk(cb(CB_A_R1) | cb(CB_PC_REG) | cb(CB_LD_PC), SQ_JMP, UA_FETCH);
      default: return mk('0, SQ_JMP, UA_FETCH);
    endcase
  endfunction
endpackage

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int OP_W  = 5,
  parameter int XOP_W = 12,
  parameter int AW    = 6
) (
  input  logic [OP_W-1:0]  op,
  input  logic [XOP_W-1:0] xop,
  output logic [AW-1:0]    entry
);
  int sel;

  always_comb begin
    sel = UA_TRAP;
    if (op == '0) begin
      if (xop == '0)                    sel = UA_ADD;
      else if (32'(xop) <= 32'd10)      sel = UA_BOP;
      else if (32'(xop) == 32'd11)      sel = UA_LDX;
      else if (32'(xop) == 32'd12)      sel = UA_STX;
    end else begin
      case (32'(op))
        32'd1:   sel = UA_LDA;
        32'd2:   sel = UA_LDD;
        32'd3:   sel = UA_STA;
        32'd4:   sel = UA_STD;
        32'd5:   sel = UA_JCC;
        32'd6:   sel = UA_JAL;
        32'd7:   sel = UA_JR;
        32'd8:   sel = UA_LDI;
        default: if (32'(op) >= 32'd9 && 32'(op) <= 32'd19) sel = UA_OPIM;
      endcase
    end
    entry = AW'(sel);
  end
endmodule

// File: rtl/useq_cond.sv
module useq_cond #(
  parameter int SEL_W = 5
) (
  input  logic [SEL_W-1:0] code,
  input  logic             zf,
  input  logic             nf,
  output logic             hit
);
  always_comb begin
    case (32'(code))
      32'd0:   hit = 1'b1;
      32'd1:   hit = zf;
      32'd2:   hit = !zf;
      32'd3:   hit = nf;
      32'd4:   hit = nf | zf;
      32'd5:   hit = !nf;
      32'd6:   hit = !nf & !zf;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  output uword_t        word_q
);
  localparam int DEPTH = 1 << AW;

  uword_t rom [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) rom[i] = uword_at(i);
  end

  always_ff @(posedge clk) begin
    word_q <= rom[rd_addr];
  end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int AW    = 6,
  parameter int OP_W  = 5,
  parameter int XOP_W = 12,
  parameter int SEL_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   ir_op,
  input  logic [XOP_W-1:0]  ir_xop,
  input  logic [SEL_W-1:0]  ir_r1,
  input  logic              flag_zero,
  input  logic              flag_neg,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [AW-1:0]     upc_o
);
  localparam logic [AW-1:0] FETCH_A = AW'(UA_FETCH);

  uword_t        cur;
  logic [AW-1:0] entry, nxt, rd_addr, upc_inc, tgt;
  logic          cond_hit;

  useq_dispatch #(.OP_W(OP_W), .XOP_W(XOP_W), .AW(AW)) u_dispatch (
    .op(ir_op), .xop(ir_xop), .entry(entry)
  );

  useq_cond #(.SEL_W(SEL_W)) u_cond (
    .code(ir_r1), .zf(flag_zero), .nf(flag_neg), .hit(cond_hit)
  );

  assign upc_inc = upc_o + AW'(1);
  assign tgt     = AW'(cur.tgt);

  always_comb begin
    case (cur.op)
      SQ_JMP:    nxt = tgt;
      SQ_JF:     nxt = cond_hit ? upc_inc : tgt;
      SQ_JT:     nxt = cond_hit ? tgt : upc_inc;
      SQ_DECODE: nxt = entry;
      default:   nxt = upc_inc;
    endcase
  end

  assign rd_addr = rst ? FETCH_A : nxt;

  useq_store #(.AW(AW)) u_store (
    .clk(clk), .rd_addr(rd_addr), .word_q(cur)
  );

  always_ff @(posedge clk) begin
    upc_o <= rd_addr;
  end

  assign ctrl_o = cur.ctrl;
endmodule

// File: rtl/useq_sequencer_chk.sv
module useq_sequencer_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic [24:0]   ctrl_o,
  input logic [AW-1:0] upc_o
);
  logic rst_d = 1'b0;

  always_ff @(posedge clk) begin
    rst_d <= rst;
  end

  always @(posedge clk) begin
    if (rst_d) begin
      assert_reset_fetch_R1: assert (upc_o == '0 && ctrl_o[18] && !ctrl_o[20]);
    end
  end

  assert_fetch_step_R2: assert property (@(posedge clk) disable iff (rst)
    (upc_o == AW'(0)) |=> (upc_o == AW'(1)));

  assert_ir_load_only_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    ctrl_o[20] |-> (upc_o == AW'(1)));

  assert_dispatch_range_R3: assert property (@(posedge clk) disable iff (rst)
    (upc_o == AW'(1)) |=> (upc_o >= AW'(2) && upc_o <= AW'(29)));

  assert_return_fetch_R4: assert property (@(posedge clk) disable iff (rst)
    (upc_o == AW'(3) || upc_o == AW'(9) || upc_o == AW'(13) || upc_o == AW'(29)
     || upc_o == AW'(27) || upc_o == AW'(28)) |=> (upc_o == AW'(0)));

  assert_jcc_paths_R7: assert property (@(posedge clk) disable iff (rst)
    (upc_o == AW'(25)) |=> (upc_o == AW'(0) || upc_o == AW'(26)));

  assert_write_last_R8: assert property (@(posedge clk) disable iff (rst)
    ctrl_o[17] |=> (upc_o == AW'(0)));
endmodule

bind useq_sequencer useq_sequencer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .ctrl_o(ctrl_o), .upc_o(upc_o)
);

// File: tb/useq_sequencer_tb.sv
module useq_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  ir_op = '0;
  logic [11:0] ir_xop = '0;
  logic [4:0]  ir_r1 = '0;
  logic        flag_zero = 1'b0;
  logic        flag_neg = 1'b0;
  logic [24:0] ctrl_o;
  logic [5:0]  upc_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int    addr;
    bit    lir;
    bit    mw;
    string tag;
  } exp_t;

  exp_t sb[$];

  always #10 clk = ~clk;

  useq_sequencer u_dut (
    .clk(clk), .rst(rst), .ir_op(ir_op), .ir_xop(ir_xop), .ir_r1(ir_r1),
    .flag_zero(flag_zero), .flag_neg(flag_neg), .ctrl_o(ctrl_o), .upc_o(upc_o)
  );

  function automatic int exp_entry(input int op, input int xop);
    if (op == 0) begin
      if (xop == 0) return 2;
      if (xop <= 10) return 4;
      if (xop == 11) return 14;
      if (xop == 12) return 22;
      return 29;
    end
    case (op)
      1: return 8;
      2: return 11;
      3: return 17;
      4: return 19;
      5: return 25;
      6: return 27;
      7: return 28;
      8: return 10;
      default: return (op >= 9 && op <= 19) ? 6 : 29;
    endcase
  endfunction

  function automatic bit exp_cond(input int code, input bit z, input bit n);
    case (code)
      0: return 1'b1;
      1: return z;
      2: return !z;
      3: return n;
      4: return n || z;
      5: return !n;
      6: return !n && !z;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int exp_len(input int ent, input bit c);
    case (ent)
      2, 4, 6, 8, 17:  return 2;
      11, 14, 19, 22:  return 3;
      25:              return c ? 2 : 1;
      default:         return 1;
    endcase
  endfunction

  function automatic void push(input int a, input string tag);
    exp_t e;
    e.addr = a;
    e.lir  = (a == 1);
    e.mw   = (a == 18 || a == 21 || a == 24);
    e.tag  = tag;
    sb.push_back(e);
  endfunction

  // called at a falling edge while upc_o is 0
  task automatic run_instr(input int op, input int xop, input int r1,
                           input bit z, input bit n, input string tag);
    int ent;
    int len;
    ir_op     = 5'(op);
    ir_xop    = 12'(xop);
    ir_r1     = 5'(r1);
    flag_zero = z;
    flag_neg  = n;
    ent = exp_entry(op, xop);
    len = exp_len(ent, exp_cond(r1, z, n));
    push(0, tag);
    push(1, tag);
    for (int i = 0; i < len; i++) push(ent + i, tag);
    repeat (2 + len) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // monitor: compare each cycle against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (!rst && sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(upc_o == 6'(e.addr), {e.tag, " upc"}, int'(upc_o), e.addr);
        check(ctrl_o[20] == e.lir, {e.tag, " ir-load"}, int'(ctrl_o[20]), int'(e.lir));
        check(ctrl_o[17] == e.mw, {e.tag, " mem-write"}, int'(ctrl_o[17]), int'(e.mw));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(upc_o == 6'd0, "R1 reset upc", int'(upc_o), 0);
    check(ctrl_o[18] && ctrl_o[19] && !ctrl_o[20], "R1 reset ctrl", int'(ctrl_o[20:18]), 3);
    rst = 1'b0;

    run_instr(0, 0, 0, 0, 0, "R2");
    run_instr(0, 1, 0, 0, 0, "R3");
    run_instr(0, 10, 0, 0, 0, "R3");
    run_instr(0, 11, 0, 0, 0, "R4");
    run_instr(0, 12, 0, 0, 0, "R8");
    run_instr(0, 13, 0, 0, 0, "R3");
    run_instr(0, 4095, 0, 0, 0, "R3");
    run_instr(1, 0, 0, 0, 0, "R4");
    run_instr(2, 0, 0, 0, 0, "R4");
    run_instr(3, 0, 0, 0, 0, "R8");
    run_instr(4, 7, 0, 0, 0, "R8");
    run_instr(6, 0, 0, 0, 0, "R4");
    run_instr(7, 0, 0, 0, 0, "R4");
    run_instr(8, 0, 0, 0, 0, "R4");
    run_instr(9, 0, 0, 0, 0, "R3");
    run_instr(19, 0, 0, 0, 0, "R3");
    run_instr(20, 0, 0, 0, 0, "R3");
    run_instr(31, 0, 0, 0, 0, "R3");
    run_instr(5, 0, 0, 0, 0, "R7");
    run_instr(5, 0, 1, 1, 0, "R5");
    run_instr(5, 0, 1, 0, 0, "R5");
    run_instr(5, 0, 2, 0, 1, "R5");
    run_instr(5, 0, 2, 1, 0, "R5");
    run_instr(5, 0, 3, 0, 1, "R5");
    run_instr(5, 0, 3, 0, 0, "R5");
    run_instr(5, 0, 4, 1, 0, "R5");
    run_instr(5, 0, 4, 0, 0, "R5");
    run_instr(5, 0, 5, 0, 0, "R5");
    run_instr(5, 0, 5, 0, 1, "R5");
    run_instr(5, 0, 6, 0, 0, "R5");
    run_instr(5, 0, 6, 1, 0, "R5");
    run_instr(5, 0, 7, 1, 1, "R6");
    run_instr(5, 0, 7, 0, 0, "R6");
    run_instr(5, 0, 31, 1, 0, "R6");

    // R1: reset in the dispatch cycle wins over the dispatch
    ir_op  = 5'd2;
    ir_xop = '0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(upc_o == 6'd0, "R1 reset over dispatch upc", int'(upc_o), 0);
    check(!ctrl_o[20], "R1 reset over dispatch ir-load", int'(ctrl_o[20]), 0);
    rst = 1'b0;
    run_instr(2, 0, 0, 0, 0, "R1");

    repeat (2) @(negedge clk);
    check(sb.size() == 0, "R4 scoreboard drained", sb.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule